// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a scalar floating-point unit. It collects sticky exception causes, the fraction-rounded and fraction-inexact indicators and the five-bit result class reported by the arithmetic datapath. It also holds the five trap enables, the non-IEEE mode bit and the two-bit rounding mode. The invalid-operation summary and the enabled-exception summary are derived from the stored bits and are never written. An interrupt request leaves the block whenever an enabled exception is pending and either of two trap-mode inputs is set.

Software-visible instructions reach the block as commands on a valid/ready channel. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a rising clock edge. `cmd_ready` is low only while the single response slot holds a result that the consumer has not taken. Every accepted command produces exactly one response beat. That beat stays stable while `rsp_valid` is high and `rsp_ready` is low. Datapath reports use a second valid/ready channel. A report is refused, with `rpt_ready` low, in any cycle in which a command is accepted, so commands take priority.

Field numbering runs 0 to 7 from the most significant nibble: field `f` covers bits `4*(7-f)+3 .. 4*(7-f)`. Single-bit commands address bits by their position, 0 to 31, counted from the LSB.

Top module: `fpu_status_reg`

## Requirements
- R1: After reset every stored bit is 0. A read command (`cmd_op`=0) returns `{32'h0, status}` on `rsp_data`, where status includes the derived bits 30 and 29.
- R2: An accepted report ORs `rpt_sticky` into the register only at the sticky cause positions: bits 28..25 (overflow, underflow, zero-divide, inexact), bits 24..19 and bits 10..8 (the nine invalid causes). Report bits at all other positions have no effect. Bit 18 takes `rpt_fr` and bit 17 takes `rpt_fi`. Bits 16..12 take `rpt_class` only when `rpt_class_en` is 1.
- R3: Bit 31 (exception summary) is set by a report that turns at least one sticky cause bit from 0 to 1. A report whose causes are all already set leaves bit 31 unchanged. Bit 31 stays set until a command clears it.
- R4: Bit 29 always reads as the OR of the nine invalid cause bits (24..19 and 10..8).
- R5: Bit 30 always reads as 1 exactly when some bit among 29..25 is set together with the enable five positions lower, among 7..3 (29 with 7, 28 with 6, 27 with 5, 26 with 4, 25 with 3).
- R6: Field move (`cmd_op`=1) returns, in `rsp_data[3:0]` with all higher bits zero, the nibble of field `cmd_field` as it read before the command. It then clears the stored bits of that field.
- R7: Bit clear (`cmd_op`=2) clears bit `cmd_bit`. It has no effect when `cmd_bit` is 30 or 29. Its response data is zero, as for opcodes 3, 4 and 5.
- R8: Bit set (`cmd_op`=3) sets bit `cmd_bit`. It has no effect when `cmd_bit` is 30, 29 or 2.
- R9: Immediate write (`cmd_op`=4) loads `cmd_imm` into field `cmd_field` and leaves the other fields unchanged.
- R10: Masked write (`cmd_op`=5) copies, for each set bit k of `cmd_mask`, bits 4k+3..4k of `cmd_src` into the same bits of the register. `cmd_src[63:32]` is ignored.
- R11: Every response carries on `rsp_cc` bits 15..12 of the register after the command's update. `rsp_cc_valid` equals the command's `cmd_rec`.
- R12: `irq` is high exactly when bit 30 is 1 and `fe0` or `fe1` is 1. It reflects the register one cycle after the update edge.
- R13: While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `cmd_ready` is low. `rpt_ready` is low in any cycle in which a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe0 | input | 1 | Trap mode bit 0 |
| fe1 | input | 1 | Trap mode bit 1 |
| rpt_valid | input | 1 | Datapath report valid |
| rpt_ready | output | 1 | Report accepted this cycle when high with valid |
| rpt_sticky | input | 32 | Exception causes at register positions |
| rpt_fr | input | 1 | Fraction rounded indicator |
| rpt_fi | input | 1 | Fraction inexact indicator |
| rpt_class_en | input | 1 | Load the result class |
| rpt_class | input | 5 | Result class and condition code |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted this cycle when high with valid |
| cmd_op | input | 3 | 0 read, 1 move field, 2 clear bit, 3 set bit, 4 immediate, 5 masked write |
| cmd_field | input | 3 | Field index, 0 is the top nibble |
| cmd_bit | input | 5 | Bit position from LSB |
| cmd_imm | input | 4 | Immediate nibble |
| cmd_mask | input | 8 | Field write mask, bit k covers bits 4k+3..4k |
| cmd_src | input | 64 | Masked write operand |
| cmd_rec | input | 1 | Record form: qualify the condition code |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 64 | Read or field-move result |
| rsp_cc | output | 4 | Condition code after the update |
| rsp_cc_valid | output | 1 | Copy of the command's record flag |
| irq | output | 1 | Enabled-exception interrupt request |

## Verification
A corrupted stored bit shows on the very next read or field-move response. It also shows through the derived bits 30 and 29, and through `irq` one cycle after the faulty update edge. A wrong summary derivation shows as a wrong bit 29 or 30 in a read response, or as a wrong `irq` level, without any further command. A broken back-pressure path shows as a lost, duplicated or changed response in the scoreboard ordering, in the cycle the consumer takes the beat.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;
  localparam int REG_W    = 32;
  localparam int FLD_W    = 4;
  localparam int N_FLD    = REG_W / FLD_W;
  localparam int OPND_W   = 64;
  localparam int CLASS_W  = 5;
  localparam int N_EXC    = 5;
  localparam int BIT_W    = $clog2(REG_W);
  localparam int FSEL_W   = $clog2(N_FLD);
  localparam int LOG_FLD  = $clog2(FLD_W);

  localparam int BIT_FX   = 31;
  localparam int BIT_FEX  = 30;
  localparam int BIT_VX   = 29;
  localparam int BIT_FR   = 18;
  localparam int BIT_FI   = 17;
  localparam int CLASS_LO = 12;
  localparam int CC_LO    = 12;
  localparam int BIT_NI   = 2;
  localparam int EXC_LO   = 25;
  localparam int EN_LO    = 3;

  // nine invalid-operation causes
  localparam logic [REG_W-1:0] INVALID_MASK = 32'h01F8_0700;
  // all sticky causes: invalid ones plus overflow, underflow, zero-divide, inexact
  localparam logic [REG_W-1:0] STICKY_MASK  = 32'h1FF8_0700;

  typedef enum logic [2:0] {
    OP_READ = 3'd0,
    OP_MOVE = 3'd1,
    OP_CLR  = 3'd2,
    OP_SET  = 3'd3,
    OP_IMM  = 3'd4,
    OP_MASK = 3'd5
  } fpscr_op_e;
endpackage

// File: rtl/fpscr_summary.sv
module fpscr_summary
  import fpscr_pkg::*;
(
  input  logic [REG_W-1:0] stored,
  output logic [REG_W-1:0] status
);
  logic             any_invalid;
  logic [N_EXC-1:0] exc_bits;
  logic [N_EXC-1:0] en_bits;
  logic [N_EXC-1:0] hit;

  assign any_invalid = |(stored & INVALID_MASK);
  assign exc_bits    = {any_invalid, stored[EXC_LO +: N_EXC-1]};
  assign en_bits     = stored[EN_LO +: N_EXC];

  for (genvar i = 0; i < N_EXC; i++) begin : g_pair
    assign hit[i] = exc_bits[i] & en_bits[i];
  end

  always_comb begin
    status          = stored;
    status[BIT_VX]  = any_invalid;
    status[BIT_FEX] = |hit;
  end
endmodule

// File: rtl/fpscr_update.sv
module fpscr_update
  import fpscr_pkg::*;
(
  input  logic [REG_W-1:0]   stored,
  input  logic [REG_W-1:0]   status,
  input  logic               cmd_fire,
  input  logic [2:0]         cmd_op,
  input  logic [FSEL_W-1:0]  cmd_field,
  input  logic [BIT_W-1:0]   cmd_bit,
  input  logic [FLD_W-1:0]   cmd_imm,
  input  logic [N_FLD-1:0]   cmd_mask,
  input  logic [REG_W-1:0]   src_lo,
  input  logic               rpt_fire,
  input  logic [REG_W-1:0]   rpt_sticky,
  input  logic               rpt_fr,
  input  logic               rpt_fi,
  input  logic               rpt_class_en,
  input  logic [CLASS_W-1:0] rpt_class,
  output logic [REG_W-1:0]   next_stored,
  output logic [OPND_W-1:0]  rsp_word
);
  logic [FSEL_W-1:0] field_inv;
  logic [BIT_W-1:0]  shamt;
  logic [REG_W-1:0]  field_mask;
  logic [REG_W-1:0]  shifted_status;
  logic [REG_W-1:0]  imm_word;
  logic [REG_W-1:0]  masked_val;
  logic [REG_W-1:0]  new_causes;
  logic [REG_W-1:0]  fresh_causes;
  logic              summary_sel;

  assign field_inv      = FSEL_W'(N_FLD - 1) - cmd_field;
  assign shamt          = {field_inv, {LOG_FLD{1'b0}}};
  assign field_mask     = {{(REG_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << shamt;
  assign shifted_status = status >> shamt;
  assign imm_word       = {{(REG_W-FLD_W){1'b0}}, cmd_imm} << shamt;
  assign summary_sel    = (cmd_bit == BIT_W'(BIT_FEX)) || (cmd_bit == BIT_W'(BIT_VX));
  assign new_causes     = rpt_sticky & STICKY_MASK;
  assign fresh_causes   = new_causes & ~stored;

  for (genvar k = 0; k < N_FLD; k++) begin : g_fld
    assign masked_val[k*FLD_W +: FLD_W] = cmd_mask[k] ? src_lo[k*FLD_W +: FLD_W]
                                                      : stored[k*FLD_W +: FLD_W];
  end

  always_comb begin
    next_stored = stored;
    rsp_word    = '0;
    if (cmd_fire) begin
      case (fpscr_op_e'(cmd_op))
        OP_READ: rsp_word = {{(OPND_W-REG_W){1'b0}}, status};
        OP_MOVE: begin
          rsp_word    = {{(OPND_W-FLD_W){1'b0}}, shifted_status[FLD_W-1:0]};
          next_stored = stored & ~field_mask;
        end
        OP_CLR: if (!summary_sel) next_stored[cmd_bit] = 1'b0;
        OP_SET: if (!summary_sel && cmd_bit != BIT_W'(BIT_NI)) next_stored[cmd_bit] = 1'b1;
        OP_IMM:  next_stored = (stored & ~field_mask) | imm_word;
        OP_MASK: next_stored = masked_val;
        default: ;
      endcase
    end else if (rpt_fire) begin
      next_stored = stored | new_causes;
      if (|fresh_causes) next_stored[BIT_FX] = 1'b1;
      next_stored[BIT_FR] = rpt_fr;
      next_stored[BIT_FI] = rpt_fi;
      if (rpt_class_en) next_stored[CLASS_LO +: CLASS_W] = rpt_class;
    end
    next_stored[BIT_FEX] = 1'b0;
    next_stored[BIT_VX]  = 1'b0;
  end
endmodule

// File: rtl/fpscr_rsp_slot.sv
module fpscr_rsp_slot
  import fpscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OPND_W-1:0] data_in,
  input  logic [FLD_W-1:0]  cc_in,
  input  logic              ccv_in,
  input  logic              rsp_ready,
  output logic              space,
  output logic              rsp_valid,
  output logic [OPND_W-1:0] rsp_data,
  output logic [FLD_W-1:0]  rsp_cc,
  output logic              rsp_cc_valid
);
  assign space = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_cc       <= '0;
      rsp_cc_valid <= 1'b0;
    end else if (load) begin
      rsp_valid    <= 1'b1;
      rsp_data     <= data_in;
      rsp_cc       <= cc_in;
      rsp_cc_valid <= ccv_in;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
  import fpscr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fe0,
  input  logic               fe1,
  input  logic               rpt_valid,
  output logic               rpt_ready,
  input  logic [REG_W-1:0]   rpt_sticky,
  input  logic               rpt_fr,
  input  logic               rpt_fi,
  input  logic               rpt_class_en,
  input  logic [CLASS_W-1:0] rpt_class,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [FSEL_W-1:0]  cmd_field,
  input  logic [BIT_W-1:0]   cmd_bit,
  input  logic [FLD_W-1:0]   cmd_imm,
  input  logic [N_FLD-1:0]   cmd_mask,
  input  logic [OPND_W-1:0]  cmd_src,
  input  logic               cmd_rec,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [OPND_W-1:0]  rsp_data,
  output logic [FLD_W-1:0]   rsp_cc,
  output logic               rsp_cc_valid,
  output logic               irq
);
  logic [REG_W-1:0]  stored_q;
  logic [REG_W-1:0]  status_vis;
  logic [REG_W-1:0]  stored_d;
  logic [OPND_W-1:0] rsp_word;
  logic              slot_space;
  logic              cmd_fire;
  logic              rpt_fire;
  logic              unused_src_hi;

  assign unused_src_hi = ^cmd_src[OPND_W-1:REG_W];
  assign cmd_ready     = slot_space;
  assign cmd_fire      = cmd_valid && slot_space;
  assign rpt_ready     = !cmd_fire;
  assign rpt_fire      = rpt_valid && rpt_ready;

  fpscr_summary u_summary (
    .stored (stored_q),
    .status (status_vis)
  );

  fpscr_update u_update (
    .stored       (stored_q),
    .status       (status_vis),
    .cmd_fire     (cmd_fire),
    .cmd_op       (cmd_op),
    .cmd_field    (cmd_field),
    .cmd_bit      (cmd_bit),
    .cmd_imm      (cmd_imm),
    .cmd_mask     (cmd_mask),
    .src_lo       (cmd_src[REG_W-1:0]),
    .rpt_fire     (rpt_fire),
    .rpt_sticky   (rpt_sticky),
    .rpt_fr       (rpt_fr),
    .rpt_fi       (rpt_fi),
    .rpt_class_en (rpt_class_en),
    .rpt_class    (rpt_class),
    .next_stored  (stored_d),
    .rsp_word     (rsp_word)
  );

  fpscr_rsp_slot u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cmd_fire),
    .data_in      (rsp_word),
    .cc_in        (stored_d[CC_LO +: FLD_W]),
    .ccv_in       (cmd_rec),
    .rsp_ready    (rsp_ready),
    .space        (slot_space),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_cc       (rsp_cc),
    .rsp_cc_valid (rsp_cc_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stored_q <= '0;
    else        stored_q <= stored_d;
  end

  assign irq = status_vis[BIT_FEX] && (fe0 || fe1);
endmodule

// File: rtl/fpscr_checker.sv
module fpscr_checker
  import fpscr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [BIT_W-1:0]  cmd_bit,
  input logic              rpt_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [OPND_W-1:0] rsp_data,
  input logic [FLD_W-1:0]  rsp_cc,
  input logic              irq,
  input logic              fe0,
  input logic              fe1,
  input logic [REG_W-1:0]  status_vis
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  p_hold_rsp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_cc));

  p_stall_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !cmd_ready);

  p_cmd_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !rpt_ready);

  p_fx_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_vis[BIT_FX] && !fire |=> status_vis[BIT_FX]);

  p_clr_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 3'd2 && (cmd_bit == BIT_W'(BIT_FEX) || cmd_bit == BIT_W'(BIT_VX))
    |=> $stable(status_vis[BIT_FEX:BIT_VX]));

  p_set_ni_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 3'd3 && cmd_bit == BIT_W'(BIT_NI) |=> $stable(status_vis[BIT_NI]));

  p_irq_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fe0 || fe1) && status_vis[BIT_FEX]);

  p_summary_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_vis[BIT_FEX] |-> |(status_vis[EXC_LO +: N_EXC] & status_vis[EN_LO +: N_EXC]));
endmodule

bind fpu_status_reg fpscr_checker u_fpscr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_bit    (cmd_bit),
  .rpt_ready  (rpt_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_cc     (rsp_cc),
  .irq        (irq),
  .fe0        (fe0),
  .fe1        (fe1),
  .status_vis (status_vis)
);

// File: tb/fpu_status_reg_bench.sv
module fpu_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fe0 = 1'b0, fe1 = 1'b0;
  logic        rpt_valid = 1'b0;
  logic        rpt_ready;
  logic [31:0] rpt_sticky = '0;
  logic        rpt_fr = 1'b0, rpt_fi = 1'b0, rpt_class_en = 1'b0;
  logic [4:0]  rpt_class = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_field = '0;
  logic [4:0]  cmd_bit = '0;
  logic [3:0]  cmd_imm = '0;
  logic [7:0]  cmd_mask = '0;
  logic [63:0] cmd_src = '0;
  logic        cmd_rec = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic [3:0]  rsp_cc;
  logic        rsp_cc_valid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit timed_out = 0;

  typedef struct {
    logic [63:0] data;
    logic [3:0]  cc;
    logic        ccv;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] model = '0;

  always #4 clk = ~clk;

  fpu_status_reg u_fpu_status_reg (.*);

  function automatic logic [31:0] seen(input logic [31:0] s);
    logic [31:0] r;
    r = s;
    r[29] = |{s[24:19], s[10:8]};
    r[30] = (r[29] & r[7]) | (r[28] & r[6]) | (r[27] & r[5]) | (r[26] & r[4]) | (r[25] & r[3]);
    return r;
  endfunction

  task automatic send_cmd(input logic [2:0] op, input logic [2:0] fld, input logic [4:0] b,
                          input logic [3:0] imm, input logic [7:0] msk, input logic [63:0] src,
                          input logic rec, input string tag);
    exp_t e;
    bit acc;
    int sh;
    e.data = '0;
    sh = 4 * (7 - fld);
    case (op)
      3'd0: e.data = {32'h0, seen(model)};
      3'd1: begin
        e.data = 64'((seen(model) >> sh) & 32'hF);
        model = model & ~(32'hF << sh);
      end
      3'd2: if (b != 30 && b != 29) model[b] = 1'b0;
      3'd3: if (b != 30 && b != 29 && b != 2) model[b] = 1'b1;
      3'd4: model = (model & ~(32'hF << sh)) | (32'(imm) << sh);
      3'd5: for (int k = 0; k < 8; k++) if (msk[k]) model[4*k +: 4] = src[4*k +: 4];
      default: ;
    endcase
    model[30] = 1'b0;
    model[29] = 1'b0;
    e.cc  = model[15:12];
    e.ccv = rec;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_op = op; cmd_field = fld; cmd_bit = b; cmd_imm = imm;
    cmd_mask = msk; cmd_src = src; cmd_rec = rec; cmd_valid = 1'b1;
    acc = 0;
    while (!acc) begin
      #2;
      acc = cmd_ready;
      if (acc) begin
        checks++;
        if (rpt_ready !== 1'b0) begin
          errors++;
          $display("FAIL R13: rpt_ready=%b expected 0 during command accept", rpt_ready);
        end
      end
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_rpt(input logic [31:0] stk, input logic fr, input logic fi,
                          input logic cen, input logic [4:0] cls);
    logic [31:0] nw;
    bit acc;
    nw = stk & 32'h1FF8_0700;
    if ((nw & ~model) != 0) model[31] = 1'b1;
    model = model | nw;
    model[18] = fr;
    model[17] = fi;
    if (cen) model[16:12] = cls;
    @(negedge clk);
    rpt_sticky = stk; rpt_fr = fr; rpt_fi = fi; rpt_class_en = cen; rpt_class = cls;
    rpt_valid = 1'b1;
    acc = 0;
    while (!acc) begin
      #2;
      acc = rpt_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    rpt_valid = 1'b0;
  endtask

  task automatic check_irq(input string tag);
    logic ex;
    #1;
    ex = seen(model)[30] & (fe0 | fe1);
    checks++;
    if (irq !== ex) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, ex);
    end
  endtask

  // response monitor with back-pressure
  always begin
    exp_t e;
    @(negedge clk);
    cyc++;
    rsp_ready = (cyc % 3) != 0;
    #3;
    if (rst_n && rsp_valid && !rsp_ready) begin
      checks++;
      if (cmd_ready !== 1'b0) begin
        errors++;
        $display("FAIL R13: cmd_ready=%b expected 0 while response stalled", cmd_ready);
      end
    end
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13: unexpected response data=%h expected none", rsp_data);
      end else begin
        e = exp_q.pop_front();
        if (rsp_data !== e.data || rsp_cc_valid !== e.ccv || (e.ccv && rsp_cc !== e.cc)) begin
          errors++;
          $display("FAIL %s: data=%h cc=%h ccv=%b expected data=%h cc=%h ccv=%b",
                   e.tag, rsp_data, rsp_cc, rsp_cc_valid, e.data, e.cc, e.ccv);
        end
      end
    end
  end

  task automatic stimulus();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b1, "R1 reset read");
    check_irq("R1 irq after reset");
    // R2 R3: overflow cause plus non-sticky junk, class load
    send_rpt(32'h5000_0084, 1'b1, 1'b0, 1'b1, 5'h11);
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R2 R3 first report");
    send_rpt(32'h1000_0000, 1'b0, 1'b1, 1'b0, 5'h03);
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R2 class kept when disabled");
    send_cmd(3'd2, 0, 5'd31, 0, 0, 0, 1'b0, "R7 clear summary bit 31");
    send_rpt(32'h1000_0000, 1'b0, 1'b0, 1'b0, 5'h00);
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R3 repeated cause leaves bit 31 clear");
    send_rpt(32'h0000_0200, 1'b0, 1'b0, 1'b0, 5'h00);
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R4 invalid cause sets bit 29");
    send_cmd(3'd3, 0, 5'd6, 0, 0, 0, 1'b1, "R5 enable overflow");
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R5 enabled summary read");
    check_irq("R12 modes off");
    @(negedge clk); fe0 = 1'b1; check_irq("R12 fe0");
    @(negedge clk); fe0 = 1'b0; fe1 = 1'b1; check_irq("R12 fe1");
    @(negedge clk); fe1 = 1'b0;
    send_cmd(3'd2, 0, 5'd30, 0, 0, 0, 1'b1, "R7 R11 clear bit 30 ignored");
    send_cmd(3'd2, 0, 5'd29, 0, 0, 0, 1'b0, "R7 clear bit 29 ignored");
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R7 summaries intact");
    send_cmd(3'd3, 0, 5'd2, 0, 0, 0, 1'b0, "R8 set bit 2 ignored");
    send_cmd(3'd3, 0, 5'd30, 0, 0, 0, 1'b0, "R8 set bit 30 ignored");
    send_cmd(3'd3, 0, 5'd0, 0, 0, 0, 1'b0, "R8 set rounding bit");
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R8 read after sets");
    send_cmd(3'd1, 3'd0, 0, 0, 0, 0, 1'b1, "R6 R11 move field 0");
    send_cmd(3'd1, 3'd5, 0, 0, 0, 0, 1'b0, "R6 move field 5");
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R6 fields cleared");
    @(negedge clk); fe0 = 1'b1; check_irq("R12 no enabled exception");
    send_cmd(3'd4, 3'd4, 0, 4'hA, 0, 0, 1'b1, "R9 R11 immediate field 4");
    send_cmd(3'd4, 3'd3, 0, 4'h5, 0, 0, 1'b0, "R9 immediate field 3");
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R9 read after immediates");
    send_cmd(3'd5, 0, 0, 0, 8'h81, 64'hDEAD_BEEF_F234_5678, 1'b1, "R10 R11 masked write");
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R10 read after masked write");
    check_irq("R12 after masked write");
    send_cmd(3'd5, 0, 0, 0, 8'hFF, 64'hFFFF_FFFF_0000_0000, 1'b1, "R10 upper operand ignored");
    send_cmd(3'd0, 0, 0, 0, 0, 0, 1'b0, "R10 all cleared");
    check_irq("R12 after clear");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run stalled, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule